// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of the write path of a byte-wide, page-programmed non-volatile array that is split into several independent regions. It watches every byte write (region, 17-bit address, 8-bit data) and recognises fixed multi-byte command sequences that switch a region into or out of a protected mode. In protected mode a data byte reaches the array only when the three-byte unlock sequence has been issued in the same page load. The unlock stays open until the region's program cycle ends.

Writes that are allowed are passed downstream, registered, one cycle after their strobe. Bytes that belong to a command sequence are always swallowed. A data write to a protected region without a prior unlock stores nothing. It still raises that region's dummy-busy output until the region's end-of-program pulse, so software sees the same program time as for a real write. A requested change of protect state is held pending and takes effect at the next end-of-program pulse for that region, whether or not any data followed the command. The protect flags have no reset: they start cleared at power-up and survive the reset input.

Per region, the recogniser moves through these states. SQ_IDLE goes to SQ_K1 on AA at 5555. SQ_K1 goes to SQ_K2 on 55 at 2AAA. From SQ_K2, A0 at 5555 finishes the enable/unlock sequence and returns to SQ_IDLE, while 80 at 5555 goes to SQ_K3. SQ_K3 goes to SQ_K4 on AA at 5555. SQ_K4 goes to SQ_K5 on 55 at 2AAA. SQ_K5 finishes the disable sequence on 20 at 5555 and returns to SQ_IDLE. Any other byte in any state takes the mismatch transition to SQ_IDLE.

Top module: `wp_guard`

## Requirements
- R1: After power-up every region reads unprotected (prot_on bit 0). A data write to an unprotected region appears on commit_vld, commit_region, commit_addr and commit_data in the cycle after its strobe.
- R2: The enable sequence is data AA at address 0x05555, then 55 at 0x02AAA, then A0 at 0x05555 (all hex). In an unprotected region it sets that region's prot_on to 1 in the cycle after that region's next prog_done pulse, and not earlier.
- R3: The disable sequence is six writes: AA@0x05555, 55@0x02AAA, 80@0x05555, AA@0x05555, 55@0x02AAA, 20@0x05555. It clears prot_on in the cycle after that region's next prog_done pulse, and not earlier.
- R4: A data write to a protected region without an open unlock is not committed. It sets dummy_busy for that region in the next cycle, and the bit stays high until the cycle after that region's prog_done.
- R5: In a protected region, after the enable sequence, data writes are committed until that region's next prog_done. Data writes after that pulse are blocked again.
- R6: A byte that does not match the next expected sequence byte returns the recogniser to SQ_IDLE and is handled as a data write under R1, R4 or R5. Bytes matched earlier in the sequence stay uncommitted.
- R7: No byte that is accepted as part of a command sequence is ever committed, in either protect state.
- R8: Asserting rst_n low leaves every prot_on bit unchanged. It clears recogniser progress, pending changes, open unlocks and dummy_busy.
- R9: Regions are independent. Strobes and prog_done pulses for one region never change prot_on or dummy_busy of another region.
- R10: When a write and prog_done hit the same region in the same cycle, the write is judged against the state before the pulse. Anything the write sets (unlock, pending change, dummy_busy) survives the clear done by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (does not touch protect flags) |
| wr_stb | input | 1 | Byte write strobe, one cycle per byte |
| wr_region | input | RGN_W (2) | Region index of the write |
| wr_addr | input | ADDR_W (17) | Byte address within the region |
| wr_data | input | DATA_W (8) | Write data |
| prog_done | input | NUM_REGIONS (4) | End-of-program-cycle pulse, one bit per region |
| commit_vld | output | 1 | A permitted data write is being passed downstream |
| commit_region | output | RGN_W (2) | Region of the passed write |
| commit_addr | output | ADDR_W (17) | Address of the passed write |
| commit_data | output | DATA_W (8) | Data of the passed write |
| prot_on | output | NUM_REGIONS (4) | Protect flag per region |
| dummy_busy | output | NUM_REGIONS (4) | Busy without storing, per region, after a blocked write |

## Verification
The end-of-program pulse and a byte write can reach the same region in one cycle. That is where the unlock is cleared, pending changes are applied and dummy-busy falls, while the write may itself open an unlock or block. The bench provokes this overlap deliberately three ways: a data write with an unlock open, a blocked write while dummy-busy is already high, and the final unlock byte landing on the pulse. In each case the reference model judges the write against the state before the pulse, and the next write shows whether the unlock survived.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Recogniser progress through the command sequences
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_K3   = 3'd3,
        SQ_K4   = 3'd4,
        SQ_K5   = 3'd5
    } seq_state_e;

    // Per-byte result reported by the recogniser
    typedef struct packed {
        logic is_cmd;   // byte consumed as a sequence byte
        logic fin_on;   // enable/unlock sequence completed
        logic fin_off;  // disable sequence completed
    } seq_ev_t;

endpackage

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
    import wp_pkg::*;
#(
    parameter int          ADDR_W   = 17,
    parameter int          DATA_W   = 8,
    parameter logic [16:0] KEY_A    = 17'h05555,
    parameter logic [16:0] KEY_B    = 17'h02AAA,
    parameter logic [7:0]  KEY_D1   = 8'hAA,
    parameter logic [7:0]  KEY_D2   = 8'h55,
    parameter logic [7:0]  CODE_ON  = 8'hA0,
    parameter logic [7:0]  CODE_PRE = 8'h80,
    parameter logic [7:0]  CODE_OFF = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output seq_ev_t           ev
);

    localparam logic [ADDR_W-1:0] AA = ADDR_W'(KEY_A);
    localparam logic [ADDR_W-1:0] AB = ADDR_W'(KEY_B);

    seq_state_e st_q, st_d;

    logic m_first, m_second, m_on, m_pre, m_off;

    assign m_first  = (addr == AA) && (data == DATA_W'(KEY_D1));
    assign m_second = (addr == AB) && (data == DATA_W'(KEY_D2));
    assign m_on     = (addr == AA) && (data == DATA_W'(CODE_ON));
    assign m_pre    = (addr == AA) && (data == DATA_W'(CODE_PRE));
    assign m_off    = (addr == AA) && (data == DATA_W'(CODE_OFF));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and per-byte event
    always_comb begin
        st_d = st_q;
        ev   = '0;
        if (hit) begin
            st_d = SQ_IDLE;
            unique case (st_q)
                SQ_IDLE: begin
                    if (m_first) begin
                        st_d      = SQ_K1;
                        ev.is_cmd = 1'b1;
                    end
                end
                SQ_K1: begin
                    if (m_second) begin
                        st_d      = SQ_K2;
                        ev.is_cmd = 1'b1;
                    end
                end
                SQ_K2: begin
                    if (m_on) begin
                        ev.is_cmd = 1'b1;
                        ev.fin_on = 1'b1;
                    end else if (m_pre) begin
                        st_d      = SQ_K3;
                        ev.is_cmd = 1'b1;
                    end
                end
                SQ_K3: begin
                    if (m_first) begin
                        st_d      = SQ_K4;
                        ev.is_cmd = 1'b1;
                    end
                end
                SQ_K4: begin
                    if (m_second) begin
                        st_d      = SQ_K5;
                        ev.is_cmd = 1'b1;
                    end
                end
                SQ_K5: begin
                    if (m_off) begin
                        ev.is_cmd  = 1'b1;
                        ev.fin_off = 1'b1;
                    end
                end
                default: st_d = SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wp_region_ctl.sv
module wp_region_ctl
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  seq_ev_t ev,
    input  logic    prog_done,
    output logic    commit_req,
    output logic    prot_on,
    output logic    unlock,
    output logic    dummy_busy
);

    // Non-volatile flag: cleared at power-up only, never by rst_n
    logic prot_q = 1'b0;
    logic pend_on_q, pend_off_q, unlock_q, busy_q;
    logic data_wr, allow, blocked;

    assign data_wr    = hit && !ev.is_cmd;
    assign allow      = !prot_q || unlock_q;
    assign commit_req = data_wr && allow;
    assign blocked    = data_wr && !allow;

    always_ff @(posedge clk) begin
        if (prog_done) begin
            if (pend_on_q) begin
                prot_q <= 1'b1;
            end else if (pend_off_q) begin
                prot_q <= 1'b0;
            end
        end
    end

    // Volatile control: the write's own effects win over the end-of-program clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_on_q  <= 1'b0;
            pend_off_q <= 1'b0;
            unlock_q   <= 1'b0;
            busy_q     <= 1'b0;
        end else begin
            if (ev.fin_on || ev.fin_off) begin
                unlock_q <= 1'b1;
            end else if (prog_done) begin
                unlock_q <= 1'b0;
            end

            if (ev.fin_on) begin
                pend_on_q  <= 1'b1;
                pend_off_q <= 1'b0;
            end else if (ev.fin_off) begin
                pend_on_q  <= 1'b0;
                pend_off_q <= 1'b1;
            end else if (prog_done) begin
                pend_on_q  <= 1'b0;
                pend_off_q <= 1'b0;
            end

            if (blocked) begin
                busy_q <= 1'b1;
            end else if (prog_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign prot_on    = prot_q;
    assign unlock     = unlock_q;
    assign dummy_busy = busy_q;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    localparam int RGN_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [RGN_W-1:0]       wr_region,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [NUM_REGIONS-1:0] prog_done,
    output logic                   commit_vld,
    output logic [RGN_W-1:0]       commit_region,
    output logic [ADDR_W-1:0]      commit_addr,
    output logic [DATA_W-1:0]      commit_data,
    output logic [NUM_REGIONS-1:0] prot_on,
    output logic [NUM_REGIONS-1:0] dummy_busy
);

    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] commit_vec;
    logic [NUM_REGIONS-1:0] unlock_vec;
    logic                   commit_any;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        seq_ev_t ev;

        assign hit_vec[g] = wr_stb && (wr_region == RGN_W'(g));

        wp_seq_fsm #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_vec[g]),
            .addr  (wr_addr),
            .data  (wr_data),
            .ev    (ev)
        );

        wp_region_ctl u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit_vec[g]),
            .ev         (ev),
            .prog_done  (prog_done[g]),
            .commit_req (commit_vec[g]),
            .prot_on    (prot_on[g]),
            .unlock     (unlock_vec[g]),
            .dummy_busy (dummy_busy[g])
        );
    end

    assign commit_any = |commit_vec;

    // Downstream stage for permitted writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_vld    <= 1'b0;
            commit_region <= '0;
            commit_addr   <= '0;
            commit_data   <= '0;
        end else begin
            commit_vld <= commit_any;
            if (commit_any) begin
                commit_region <= wr_region;
                commit_addr   <= wr_addr;
                commit_data   <= wr_data;
            end
        end
    end

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int NUM_REGIONS = 4,
    parameter int RGN_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_stb,
    input logic [RGN_W-1:0]       wr_region,
    input logic [NUM_REGIONS-1:0] prog_done,
    input logic                   commit_vld,
    input logic [RGN_W-1:0]       commit_region,
    input logic [NUM_REGIONS-1:0] prot_on,
    input logic [NUM_REGIONS-1:0] dummy_busy,
    input logic [NUM_REGIONS-1:0] unlock_vec
);

    logic [NUM_REGIONS-1:0] open_vec;
    logic [NUM_REGIONS-1:0] strobe_vec;

    assign open_vec = ~prot_on | unlock_vec;

    always_comb begin
        strobe_vec = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            strobe_vec[i] = wr_stb && (wr_region == RGN_W'(i));
        end
    end

    AST_COMMIT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> ($past(wr_stb) && (commit_region == $past(wr_region)))); // R1

    AST_COMMIT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> $past(open_vec[wr_region])); // R5

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(dummy_busy) & ~$past(prog_done) & ~dummy_busy) == '0)); // R4

    AST_BUSY_RISE_OWN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((dummy_busy & ~$past(dummy_busy) & ~$past(strobe_vec)) == '0)); // R9

    AST_PROT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((prot_on ^ $past(prot_on)) & ~$past(prog_done)) == '0)); // R2

endmodule

bind wp_guard wp_guard_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .RGN_W       (RGN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .wr_region     (wr_region),
    .prog_done     (prog_done),
    .commit_vld    (commit_vld),
    .commit_region (commit_region),
    .prot_on       (prot_on),
    .dummy_busy    (dummy_busy),
    .unlock_vec    (unlock_vec)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

    localparam int CLK_P = 10;
    localparam int NR    = 4;
    localparam int RW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [RW-1:0] wr_region = '0;
    logic [16:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NR-1:0] prog_done = '0;
    logic          commit_vld;
    logic [RW-1:0] commit_region;
    logic [16:0]   commit_addr;
    logic [7:0]    commit_data;
    logic [NR-1:0] prot_on;
    logic [NR-1:0] dummy_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    wp_guard dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .wr_region     (wr_region),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .prog_done     (prog_done),
        .commit_vld    (commit_vld),
        .commit_region (commit_region),
        .commit_addr   (commit_addr),
        .commit_data   (commit_data),
        .prot_on       (prot_on),
        .dummy_busy    (dummy_busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [24:0] seq_en  [3] = '{{17'h05555, 8'hAA}, {17'h02AAA, 8'h55}, {17'h05555, 8'hA0}};
    logic [24:0] seq_dis [6] = '{{17'h05555, 8'hAA}, {17'h02AAA, 8'h55}, {17'h05555, 8'h80},
                                 {17'h05555, 8'hAA}, {17'h02AAA, 8'h55}, {17'h05555, 8'h20}};
    int  m_stage [NR];
    bit  m_prot  [NR];
    bit  m_pon   [NR];
    bit  m_poff  [NR];
    bit  m_unl   [NR];
    bit  m_busy  [NR];
    bit          e_cv = 0;
    logic [RW-1:0] e_rg = '0;
    logic [16:0] e_ad = '0;
    logic [7:0]  e_dt = '0;

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_stage[i] = 0; m_prot[i] = 0; m_pon[i] = 0;
            m_poff[i] = 0; m_unl[i] = 0; m_busy[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                m_stage[i] = 0; m_pon[i] = 0; m_poff[i] = 0; m_unl[i] = 0; m_busy[i] = 0;
            end
            e_cv = 0;
        end else begin
            int  r;
            int  n;
            bit  is_cmd, fon, foff, allow;
            logic [24:0] key;
            r = int'(wr_region);
            is_cmd = 0; fon = 0; foff = 0;
            allow = !m_prot[r] || m_unl[r];
            e_cv = 0;
            if (wr_stb) begin
                n = m_stage[r];
                key = {wr_addr, wr_data};
                if (n < 3 && key == seq_en[n] && n == 2) begin
                    is_cmd = 1; fon = 1; m_stage[r] = 0;
                end else if (n < 6 && key == seq_dis[n]) begin
                    is_cmd = 1;
                    if (n == 5) begin foff = 1; m_stage[r] = 0; end
                    else m_stage[r] = n + 1;
                end else begin
                    m_stage[r] = 0;
                end
            end
            // end-of-program effects, judged on old state
            for (int i = 0; i < NR; i++) begin
                if (prog_done[i]) begin
                    if (m_pon[i]) m_prot[i] = 1;
                    else if (m_poff[i]) m_prot[i] = 0;
                    m_pon[i] = 0; m_poff[i] = 0; m_unl[i] = 0; m_busy[i] = 0;
                end
            end
            // the write's own effects win
            if (wr_stb) begin
                if (fon)  begin m_unl[r] = 1; m_pon[r] = 1; m_poff[r] = 0; end
                if (foff) begin m_unl[r] = 1; m_pon[r] = 0; m_poff[r] = 1; end
                if (!is_cmd) begin
                    if (allow) begin
                        e_cv = 1; e_rg = wr_region; e_ad = wr_addr; e_dt = wr_data;
                    end else begin
                        m_busy[r] = 1;
                    end
                end
            end
        end
    end

    // compare every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(commit_vld === e_cv, "R1 commit_vld", commit_vld, e_cv);
            if (e_cv) begin
                chk({commit_region, commit_addr, commit_data} === {e_rg, e_ad, e_dt},
                    "R1 commit fields", {commit_region, commit_addr, commit_data}, {e_rg, e_ad, e_dt});
            end
            for (int i = 0; i < NR; i++) begin
                chk(prot_on[i] === m_prot[i], "R2 prot_on", prot_on[i], m_prot[i]);
                chk(dummy_busy[i] === m_busy[i], "R4 dummy_busy", dummy_busy[i], m_busy[i]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int r, input logic [16:0] a, input logic [7:0] d, input bit with_done = 0);
        @(posedge clk); #1;
        wr_stb = 1; wr_region = RW'(r); wr_addr = a; wr_data = d;
        if (with_done) prog_done[r] = 1'b1;
        @(posedge clk); #1;
        wr_stb = 0; prog_done = '0;
    endtask

    task automatic done(input int r);
        @(posedge clk); #1;
        prog_done[r] = 1'b1;
        @(posedge clk); #1;
        prog_done = '0;
    endtask

    task automatic unlock_seq(input int r);
        wr(r, 17'h05555, 8'hAA);
        wr(r, 17'h02AAA, 8'h55);
        wr(r, 17'h05555, 8'hA0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(prot_on === 4'b0000, "R1 reset prot", prot_on, 0);
        chk(commit_vld === 1'b0, "R1 reset commit", commit_vld, 0);

        // R1: plain data write
        wr(0, 17'h00010, 8'h3C);
        @(negedge clk);
        chk(commit_vld && commit_addr == 17'h00010 && commit_data == 8'h3C, "R1 data pass", commit_data, 8'h3C);

        // R2/R7: enable region 1
        wr(1, 17'h05555, 8'hAA);
        @(negedge clk);
        chk(!commit_vld, "R7 cmd byte swallowed", commit_vld, 0);
        wr(1, 17'h02AAA, 8'h55);
        wr(1, 17'h05555, 8'hA0);
        @(negedge clk);
        chk(prot_on[1] == 1'b0, "R2 not before done", prot_on[1], 0);
        wr(1, 17'h00100, 8'h11);
        done(1);
        @(negedge clk);
        chk(prot_on[1] == 1'b1, "R2 set at done", prot_on[1], 1);
        chk(prot_on[0] == 1'b0, "R9 other region", prot_on[0], 0);

        // R4: blocked write
        wr(1, 17'h00200, 8'h22);
        @(negedge clk);
        chk(!commit_vld && dummy_busy[1], "R4 blocked busy", dummy_busy[1], 1);
        chk(dummy_busy[0] == 1'b0, "R9 busy isolated", dummy_busy[0], 0);
        wr(1, 17'h00201, 8'h23);
        done(1);
        @(negedge clk);
        chk(dummy_busy[1] == 1'b0, "R4 busy cleared", dummy_busy[1], 0);

        // R5: unlock then page load, then locked again
        unlock_seq(1);
        wr(1, 17'h00300, 8'h33);
        @(negedge clk);
        chk(commit_vld && commit_data == 8'h33, "R5 unlocked commit", commit_data, 8'h33);
        wr(1, 17'h00301, 8'h34);
        done(1);
        wr(1, 17'h00302, 8'h35);
        @(negedge clk);
        chk(!commit_vld && dummy_busy[1], "R5 relocked", commit_vld, 0);
        done(1);

        // R6: mismatch in protected and unprotected regions
        wr(1, 17'h05555, 8'hAA);
        wr(1, 17'h02AAA, 8'h77);
        @(negedge clk);
        chk(!commit_vld && dummy_busy[1], "R6 mismatch blocked", dummy_busy[1], 1);
        done(1);
        wr(2, 17'h05555, 8'hAA);
        wr(2, 17'h00100, 8'h12);
        @(negedge clk);
        chk(commit_vld && commit_data == 8'h12 && commit_region == 2'd2, "R6 mismatch committed", commit_data, 8'h12);

        // R8: reset keeps protect flag
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(prot_on[1] == 1'b1, "R8 prot survives reset", prot_on[1], 1);

        // R10: same-cycle write and prog_done
        unlock_seq(1);
        wr(1, 17'h00400, 8'h44, 1);
        @(negedge clk);
        chk(commit_vld && commit_data == 8'h44, "R10 old unlock used", commit_data, 8'h44);
        wr(1, 17'h00401, 8'h45);
        @(negedge clk);
        chk(!commit_vld && dummy_busy[1], "R10 unlock cleared", commit_vld, 0);
        wr(1, 17'h00402, 8'h46, 1);
        @(negedge clk);
        chk(dummy_busy[1] == 1'b1, "R10 busy set wins", dummy_busy[1], 1);
        done(1);
        wr(1, 17'h05555, 8'hAA);
        wr(1, 17'h02AAA, 8'h55);
        wr(1, 17'h05555, 8'hA0, 1);
        wr(1, 17'h00500, 8'h50);
        @(negedge clk);
        chk(commit_vld && commit_data == 8'h50, "R10 new unlock survives", commit_data, 8'h50);
        done(1);

        // R3: disable region 1
        wr(1, 17'h05555, 8'hAA);
        wr(1, 17'h02AAA, 8'h55);
        wr(1, 17'h05555, 8'h80);
        wr(1, 17'h05555, 8'hAA);
        wr(1, 17'h02AAA, 8'h55);
        wr(1, 17'h05555, 8'h20);
        @(negedge clk);
        chk(!commit_vld && prot_on[1], "R3 not before done", prot_on[1], 1);
        done(1);
        @(negedge clk);
        chk(prot_on[1] == 1'b0, "R3 cleared at done", prot_on[1], 0);
        wr(1, 17'h00600, 8'h66);
        @(negedge clk);
        chk(commit_vld && commit_data == 8'h66, "R3 writes free", commit_data, 8'h66);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule